// File: doc/BRIEF.md
# Pseudo-Static RAM Refresh Mode Controller

This block sits inside a pseudo-static RAM and decides which array row is refreshed and when. It samples the chip-enable and refresh-request pins on the internal clock. From what it samples, it tells apart three kinds of cycle: an ordinary access cycle, a short refresh-request pulse (auto-refresh) and a long one (self-refresh). It keeps an internal row counter and runs a periodic timer while in self-refresh. For each cycle it picks the row source for the row decoder, either the row bits of the external address or the internal counter.

Each row refresh appears as a one-cycle strobe with the chosen row and a flag naming its source. A refresh-request pulse whose length falls between the two defined windows is reported by a one-cycle flag and refreshes nothing. All pulse-width thresholds and the self-refresh period are counted in clock cycles. The period is derived so that every row is visited within the refresh window.

Top module: `psram_refresh_top`

## Requirements
- R1: After reset, rowStrobe and badPulse are 0, refMode is 0 (idle), and the internal row counter is 0, so the first counter-sourced refresh uses row 0.
- R2: In idle, a clock edge that samples ceN low after it was high, with rfshN high, gives rowStrobe for exactly one cycle after that edge. rowAddr is addrIn[ADDR_W-1:COL_W] (the upper ROW_W bits) and rowSrcInt is 0. The low COL_W address bits have no effect on rowAddr, and the counter does not move.
- R3: With ceN high, a rfshN low pulse sampled low on 1 to AUTO_MAX_CYC edges gives rowStrobe one cycle after the edge that samples it high again. That strobe carries rowAddr equal to the counter and rowSrcInt 1, and the counter then advances by one.
- R4: A pulse sampled low on more than AUTO_MAX_CYC but fewer than SELF_MIN_CYC edges gives badPulse for one cycle, no rowStrobe, and leaves the counter unchanged.
- R5: refMode reads 1 (measuring) from the edge that samples the rfshN fall with ceN high. It reads 2 (self-refresh) from the SELF_MIN_CYC-th edge that samples rfshN low.
- R6: In self-refresh, rowStrobe pulses every PERIOD cycles, the first one PERIOD cycles after entry. Each carries the counter row with rowSrcInt 1, and the rows run in sequence.
- R7: The edge that samples rfshN high in self-refresh returns refMode to 0 without a strobe. The counter keeps its value, so the next auto-refresh continues the sequence.
- R8: The counter wraps from ROWS-1 to 0.
- R9: While ceN is low, rfshN activity starts no measurement and causes no refresh. If ceN goes low during a measurement, the measurement is abandoned and nothing is refreshed.
- R10: PERIOD equals REF_WINDOW_CYC / ROWS, so ROWS self-refresh strobes fit in the refresh window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip enable, active low |
| rfshN | input | 1 | Refresh request, active low |
| addrIn | input | ADDR_W | External address; upper ROW_W bits are the row |
| rowAddr | output | ROW_W | Row sent to the row decoder |
| rowStrobe | output | 1 | One-cycle row refresh strobe |
| rowSrcInt | output | 1 | 1 when the current row came from the counter |
| badPulse | output | 1 | One-cycle flag for an undefined pulse width |
| refMode | output | 2 | 0 idle, 1 measuring, 2 self-refresh |

## Verification
Strobes for access cycles and for auto-refresh and undefined pulses are due one cycle after the edge that samples the triggering input change. A self-refresh strobe is due SELF_MIN_CYC plus k times PERIOD cycles after the edge that samples the fall. When the driver tasks make a stimulus, they push the expected item with its due cycle number into a queue. A monitor runs on the falling clock edge and pops one item for every strobe or flag seen. It compares the cycle number, row and source, and counts any output that has no matching item as a failure. refMode is sampled on the falling edge directly after the edge at which it is due.

// File: rtl/psram_refresh_pkg.sv
package psram_refresh_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE    = 2'd0,
    MODE_MEASURE = 2'd1,
    MODE_SELF    = 2'd2
  } refMode_e;

  typedef struct packed {
    logic strobeExt;
    logic strobeInt;
    logic flagBad;
  } refCmd_t;

endpackage

// File: rtl/psram_refresh_ctrl.sv
module psram_refresh_ctrl
  import psram_refresh_pkg::*;
#(
  parameter int AUTO_MAX_CYC = 8,
  parameter int SELF_MIN_CYC = 32,
  parameter int PERIOD       = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ceN,
  input  logic     rfshN,
  output refCmd_t  cmd,
  output refMode_e mode
);

  localparam int WW = $clog2(SELF_MIN_CYC + 1);
  localparam int TW = $clog2(PERIOD + 1);
  localparam logic [WW-1:0] AUTO_LIM  = WW'(AUTO_MAX_CYC);
  localparam logic [WW-1:0] SELF_LAST = WW'(SELF_MIN_CYC - 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(PERIOD - 1);

  refMode_e      stQ, stD;
  logic [WW-1:0] widthQ, widthD;
  logic [TW-1:0] timerQ, timerD;
  logic          ceQ, rfQ;

  always_comb begin
    cmd    = '0;
    stD    = stQ;
    widthD = widthQ;
    timerD = timerQ;
    case (stQ)
      MODE_IDLE: begin
        if (ceQ && !ceN && rfshN) begin
          cmd.strobeExt = 1'b1;
        end else if (ceN && rfQ && !rfshN) begin
          stD    = MODE_MEASURE;
          widthD = WW'(1);
        end
      end
      MODE_MEASURE: begin
        if (!ceN) begin
          stD = MODE_IDLE;
        end else if (rfshN) begin
          stD = MODE_IDLE;
          if (widthQ <= AUTO_LIM) cmd.strobeInt = 1'b1;
          else                    cmd.flagBad   = 1'b1;
        end else if (widthQ == SELF_LAST) begin
          stD    = MODE_SELF;
          timerD = '0;
        end else begin
          widthD = widthQ + WW'(1);
        end
      end
      MODE_SELF: begin
        if (rfshN) begin
          stD = MODE_IDLE;
        end else if (timerQ == TICK_LAST) begin
          cmd.strobeInt = 1'b1;
          timerD        = '0;
        end else begin
          timerD = timerQ + TW'(1);
        end
      end
      default: stD = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ    <= MODE_IDLE;
      widthQ <= '0;
      timerQ <= '0;
      ceQ    <= 1'b1;
      rfQ    <= 1'b1;
    end else begin
      stQ    <= stD;
      widthQ <= widthD;
      timerQ <= timerD;
      ceQ    <= ceN;
      rfQ    <= rfshN;
    end
  end

  assign mode = stQ;

endmodule

// File: rtl/psram_refresh_dp.sv
module psram_refresh_dp
  import psram_refresh_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int ROWS   = 2048,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  refCmd_t           cmd,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ROW_W-1:0]  rowAddr,
  output logic              rowStrobe,
  output logic              rowSrcInt,
  output logic              badPulse
);

  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] cntQ, cntNext, extRow, selRow;

  assign extRow  = addrIn[ADDR_W-1:COL_W];
  assign cntNext = (cntQ == ROW_LAST) ? '0 : cntQ + ROW_W'(1);
  assign selRow  = cmd.strobeInt ? cntQ : extRow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ      <= '0;
      rowAddr   <= '0;
      rowStrobe <= 1'b0;
      rowSrcInt <= 1'b0;
      badPulse  <= 1'b0;
    end else begin
      rowStrobe <= cmd.strobeExt | cmd.strobeInt;
      badPulse  <= cmd.flagBad;
      if (cmd.strobeExt | cmd.strobeInt) begin
        rowAddr   <= selRow;
        rowSrcInt <= cmd.strobeInt;
      end
      if (cmd.strobeInt) cntQ <= cntNext;
    end
  end

endmodule

// File: rtl/psram_refresh_top.sv
module psram_refresh_top
  import psram_refresh_pkg::*;
#(
  parameter int ADDR_W         = 18,
  parameter int ROWS           = 2048,
  parameter int AUTO_MAX_CYC   = 8,
  parameter int SELF_MIN_CYC   = 32,
  parameter int REF_WINDOW_CYC = 32768,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = ADDR_W - ROW_W,
  localparam int PERIOD = REF_WINDOW_CYC / ROWS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              rfshN,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ROW_W-1:0]  rowAddr,
  output logic              rowStrobe,
  output logic              rowSrcInt,
  output logic              badPulse,
  output logic [1:0]        refMode
);

  refCmd_t  cmd;
  refMode_e mode;

  psram_refresh_ctrl #(
    .AUTO_MAX_CYC(AUTO_MAX_CYC),
    .SELF_MIN_CYC(SELF_MIN_CYC),
    .PERIOD      (PERIOD)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .ceN  (ceN),
    .rfshN(rfshN),
    .cmd  (cmd),
    .mode (mode)
  );

  psram_refresh_dp #(
    .ADDR_W(ADDR_W),
    .ROWS  (ROWS),
    .ROW_W (ROW_W),
    .COL_W (COL_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .addrIn   (addrIn),
    .rowAddr  (rowAddr),
    .rowStrobe(rowStrobe),
    .rowSrcInt(rowSrcInt),
    .badPulse (badPulse)
  );

  assign refMode = mode;

endmodule

// File: rtl/psram_refresh_chk.sv
module psram_refresh_chk #(
  parameter int ROWS   = 2048,
  parameter int ROW_W  = 11,
  parameter int PERIOD = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             ceN,
  input logic             rfshN,
  input logic [ROW_W-1:0] rowAddr,
  input logic             rowStrobe,
  input logic             rowSrcInt,
  input logic             badPulse,
  input logic [1:0]       refMode
);

  localparam int GW = $clog2(PERIOD + 2);

  logic [ROW_W-1:0] lastInt, nextInt;
  logic             haveInt, selfSeen;
  logic [GW-1:0]    gap;

  assign nextInt = (lastInt == ROW_W'(ROWS - 1)) ? '0 : lastInt + ROW_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastInt  <= '0;
      haveInt  <= 1'b0;
      selfSeen <= 1'b0;
      gap      <= '0;
    end else begin
      if (rowStrobe && rowSrcInt) begin
        lastInt <= rowAddr;
        haveInt <= 1'b1;
      end
      if (refMode != 2'd2) begin
        selfSeen <= 1'b0;
        gap      <= '0;
      end else if (rowStrobe) begin
        selfSeen <= 1'b1;
        gap      <= GW'(1);
      end else if (gap != {GW{1'b1}}) begin
        gap <= gap + GW'(1);
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !rowStrobe && !badPulse && refMode == 2'd0); // R1

  AST_EXT_NEEDS_CE_FALL: assert property (@(posedge clk) disable iff (!rstN)
    rowStrobe && !rowSrcInt |-> !$past(ceN) && $past(ceN, 2)); // R2

  AST_INT_ROWS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rstN)
    rowStrobe && rowSrcInt && haveInt |-> rowAddr == nextInt); // R8

  AST_BAD_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    badPulse |-> $past(rfshN) && !$past(rfshN, 2) && !rowStrobe); // R4

  AST_SELF_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    rowStrobe && refMode == 2'd2 && selfSeen |-> gap == GW'(PERIOD)); // R6

  AST_SELF_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    refMode == 2'd2 && rfshN |=> refMode == 2'd0 && !rowStrobe); // R7

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    refMode != 2'd3); // R5

endmodule

bind psram_refresh_top psram_refresh_chk #(
  .ROWS  (ROWS),
  .ROW_W (ROW_W),
  .PERIOD(PERIOD)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ceN      (ceN),
  .rfshN    (rfshN),
  .rowAddr  (rowAddr),
  .rowStrobe(rowStrobe),
  .rowSrcInt(rowSrcInt),
  .badPulse (badPulse),
  .refMode  (refMode)
);

// File: tb/tb_psram_refresh_top.sv
`timescale 1ns/1ps
module tb_psram_refresh_top;

  localparam int ADDR_W   = 18;
  localparam int ROWS     = 2048;
  localparam int AUTO_MAX = 8;
  localparam int SELF_MIN = 32;
  localparam int WINDOW   = 32768;
  localparam int ROW_W    = $clog2(ROWS);
  localparam int COL_W    = ADDR_W - ROW_W;
  localparam int PER      = WINDOW / ROWS;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ceN = 1'b1;
  logic              rfshN = 1'b1;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [ROW_W-1:0]  rowAddr;
  logic              rowStrobe, rowSrcInt, badPulse;
  logic [1:0]        refMode;

  psram_refresh_top #(
    .ADDR_W(ADDR_W), .ROWS(ROWS), .AUTO_MAX_CYC(AUTO_MAX),
    .SELF_MIN_CYC(SELF_MIN), .REF_WINDOW_CYC(WINDOW)
  ) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .rfshN(rfshN), .addrIn(addrIn),
    .rowAddr(rowAddr), .rowStrobe(rowStrobe), .rowSrcInt(rowSrcInt),
    .badPulse(badPulse), .refMode(refMode)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int    due;
    int    row;
    bit    srcInt;
    bit    bad;
    string req;
  } exp_t;

  exp_t expQ[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   expCnt = 0;
  bit   done = 0;

  always @(posedge clk) cyc++;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(int due, int row, bit srcInt, bit bad, string req);
    exp_t e;
    e.due = due; e.row = row; e.srcInt = srcInt; e.bad = bad; e.req = req;
    expQ.push_back(e);
  endtask

  // monitor: every strobe or flag must match the oldest expected item
  always @(negedge clk) begin
    if (rstN && (rowStrobe || badPulse)) begin
      if (expQ.size() == 0) begin
        chk(0, "R9 unexpected output", int'(rowAddr), -1);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(cyc == e.due, {e.req, " due cycle"}, cyc, e.due);
        chk(badPulse == e.bad, {e.req, " bad flag"}, int'(badPulse), int'(e.bad));
        if (!e.bad) begin
          chk(rowStrobe == 1'b1, {e.req, " strobe"}, int'(rowStrobe), 1);
          chk(int'(rowAddr) == e.row, {e.req, " row"}, int'(rowAddr), e.row);
          chk(rowSrcInt == e.srcInt, {e.req, " source"}, int'(rowSrcInt), int'(e.srcInt));
        end
      end
    end
  end

  task automatic access(logic [ADDR_W-1:0] a, string req);
    @(negedge clk);
    ceN = 1'b0;
    addrIn = a;
    push(cyc + 1, int'(a >> COL_W), 1'b0, 1'b0, req);
    repeat (2) @(negedge clk);
    addrIn = ~a;
    ceN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(int len, string req);
    @(negedge clk);
    rfshN = 1'b0;
    repeat (len) @(negedge clk);
    rfshN = 1'b1;
    if (len <= AUTO_MAX) begin
      push(cyc + 1, expCnt, 1'b1, 1'b0, req);
      expCnt = (expCnt + 1) % ROWS;
    end else begin
      push(cyc + 1, 0, 1'b0, 1'b1, req);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic selfRun(int hold);
    int c0;
    @(negedge clk);
    rfshN = 1'b0;
    c0 = cyc;
    for (int k = 1; SELF_MIN + k * PER <= hold; k++) begin
      push(c0 + SELF_MIN + k * PER, expCnt, 1'b1, 1'b0, "R6 self strobe");
      expCnt = (expCnt + 1) % ROWS;
    end
    @(negedge clk);
    chk(refMode == 2'd1, "R5 measuring", int'(refMode), 1);
    repeat (SELF_MIN - 1) @(negedge clk);
    chk(refMode == 2'd2, "R5 self entry", int'(refMode), 2);
    repeat (hold - SELF_MIN) @(negedge clk);
    rfshN = 1'b1;
    @(negedge clk);
    chk(refMode == 2'd0, "R7 self exit", int'(refMode), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(rowStrobe == 1'b0, "R1 strobe", int'(rowStrobe), 0);
    chk(badPulse == 1'b0, "R1 bad", int'(badPulse), 0);
    chk(refMode == 2'd0, "R1 mode", int'(refMode), 0);

    // R2: external row, column bits ignored
    access(18'h3FFFF, "R2 all ones");
    access(18'h0007F, "R2 low bits only");
    access(18'h15555, "R2 pattern");

    // R1/R3: counter starts at 0, short pulses
    pulse(1, "R1 first counter row");
    pulse(AUTO_MAX, "R3 max auto width");

    // R4: undefined widths, counter must not move
    pulse(AUTO_MAX + 1, "R4 just above auto");
    pulse(SELF_MIN - 1, "R4 just below self");
    pulse(3, "R4 counter unchanged");

    // R5/R6/R7/R10: self refresh
    selfRun(SELF_MIN + 3 * PER + 5);
    pulse(2, "R7 resume sequence");

    // R9: CE low blocks refresh recognition
    @(negedge clk);
    ceN = 1'b0;
    addrIn = 18'h2A5C3;
    push(cyc + 1, int'(18'h2A5C3 >> COL_W), 1'b0, 1'b0, "R2 held access");
    repeat (2) @(negedge clk);
    rfshN = 1'b0;
    repeat (3) @(negedge clk);
    rfshN = 1'b1;
    repeat (2) @(negedge clk);
    rfshN = 1'b0;
    repeat (2) @(negedge clk);
    ceN = 1'b1;
    repeat (3) @(negedge clk);
    rfshN = 1'b1;
    repeat (2) @(negedge clk);
    chk(refMode == 2'd0, "R9 mode after ce low", int'(refMode), 0);
    // abort measurement by CE falling
    rfshN = 1'b0;
    repeat (3) @(negedge clk);
    ceN = 1'b0;
    repeat (2) @(negedge clk);
    chk(refMode == 2'd0, "R9 aborted", int'(refMode), 0);
    rfshN = 1'b1;
    repeat (2) @(negedge clk);
    ceN = 1'b1;
    repeat (2) @(negedge clk);
    pulse(4, "R9 counter unchanged");

    // R8: wrap the counter
    for (int i = 0; i < ROWS; i++) pulse(1, "R8 wrap");

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R6 all expected seen", expQ.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule